// File: doc/BRIEF.md
# Dual-Channel Receive Queue and Interrupt Status

This block holds the receive side of a two-channel serial controller. Each channel owns a circular character queue. The queue is filled either from an external character input or by looping back a transmitted byte, and it is drained by reads of the data location. The block keeps a receive-available status per channel, reports transmit-empty as always set, and keeps one pending register that both channels share. A single registered interrupt request is built from that register.

Control bits come in as plain inputs from a surrounding register file: a master interrupt enable, a two-bit receive interrupt mode, per-channel transmit interrupt enables and per-channel loopback enables. A data read on either channel pops one character if one is present. The same read clears the whole pending register, which acknowledges the interrupt.

Each channel runs a two-state machine. `CH_EMPTY` moves to `CH_HOLDING` on any accepted push. `CH_HOLDING` returns to `CH_EMPTY` when the next write and read indices match, which happens either when the last character is popped or when a push wraps onto the read index (overrun). The interrupt machine moves from `IRQ_QUIET` to `IRQ_RAISED` when the master enable is high and any pending bit is set, and it falls back to `IRQ_QUIET` otherwise.

Top module: `sio_rx_status`

## Requirements
- R1: Each channel has a DEPTH-entry circular queue, where DEPTH is a power of two. Characters leave the queue in the order in which they were pushed.
- R2: If a push makes the channel's write index equal to its read index, `overrun[c]` is high for exactly the one cycle after that push. From then on the queue reads as empty.
- R3: `rx_avail[c]` is high exactly when the channel's queue is non-empty, from the cycle after the push or pop that changed it. `tx_empty` always reads 2'b11.
- R4: While `master_ie` is low, no bit of `pending` rises.
- R5: If `master_ie` is high, either bit of `rx_mode` is set and `rx_avail[c]` is high, then `pending[c]` is set in the next cycle. Bit 0 belongs to channel A and bit 1 to channel B.
- R6: A data write on channel c while `master_ie` and `tx_ie[c]` are high sets `pending[2+c]` in the next cycle.
- R7: A data write on channel c while `loopback[c]` is high pushes `wr_char` into queue c. In that cycle, an external push on the same channel is dropped.
- R8: A data read on channel `acc_chan` pops one character if one is available. The character appears on `rd_char` in the next cycle. The read also clears all four pending bits, and this clear wins over any set in the same cycle.
- R9: A data read of an empty queue makes `rd_char` zero and leaves the queue unchanged.
- R10: A push and a pop on the same channel in the same cycle are both carried out.
- R11: `irq` is high in a cycle exactly when, in the previous cycle, `master_ie` was high and `pending` was non-zero.
- R12: After reset, the queues are empty and `pending`, `irq`, `overrun` and `rd_char` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_push | input | 2 | External character strobe, one bit per channel |
| ext_char | input | 16 | External characters; channel A in the low byte |
| data_rd | input | 1 | Read of the data location |
| data_wr | input | 1 | Write of the data location (transmit) |
| acc_chan | input | 1 | Channel of the data access (0 = A, 1 = B) |
| wr_char | input | 8 | Transmitted byte |
| master_ie | input | 1 | Master interrupt enable |
| rx_mode | input | 2 | Receive interrupt mode (first character / all characters) |
| tx_ie | input | 2 | Transmit interrupt enable per channel |
| loopback | input | 2 | Local loopback enable per channel |
| rd_char | output | 8 | Character returned by the last data read |
| rx_avail | output | 2 | Receive-available status per channel |
| tx_empty | output | 2 | Transmit-empty status, always set |
| overrun | output | 2 | One-cycle overrun pulse per channel |
| pending | output | 4 | Shared pending bits: [0] RX A, [1] RX B, [2] TX A, [3] TX B |
| irq | output | 1 | Registered interrupt request |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a data read, which clears `pending`, and a receive or transmit event, which sets `pending`. The second pair is a push and a pop on the same channel. Both are provoked by directed cycles that issue a read together with an external push or a loopback write, and by a long random run where reads, writes and pushes overlap freely. They are judged against a bench model that clears before it sets, and that pops from the pre-cycle head before it appends the new character.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int NUM_CH       = 2;
    localparam int PEND_W       = 4;
    localparam int PEND_RX_BASE = 0;
    localparam int PEND_TX_BASE = 2;

    typedef enum logic {
        CH_EMPTY   = 1'b0,
        CH_HOLDING = 1'b1
    } ch_state_t;

    typedef enum logic {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_t;
endpackage

// File: rtl/rxq_channel.sv
module rxq_channel
    import rxq_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int CW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [CW-1:0] push_char,
    input  logic          pop,
    output logic          avail,
    output logic [CW-1:0] head_char,
    output logic          overrun_q
);
    localparam int IW = $clog2(DEPTH);

    ch_state_t     state_q, state_n;
    logic [IW-1:0] wr_q, rd_q, wr_n, rd_n;
    logic          pop_ok;
    logic          overrun_n;
    logic [CW-1:0] mem [DEPTH];

    // a pop is honoured only when the queue holds data
    assign pop_ok    = pop && (state_q == CH_HOLDING);
    assign wr_n      = push   ? wr_q + IW'(1) : wr_q;
    assign rd_n      = pop_ok ? rd_q + IW'(1) : rd_q;
    assign overrun_n = push && (wr_n == rd_n);

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            CH_EMPTY: begin
                if (push) state_n = CH_HOLDING;
            end
            CH_HOLDING: begin
                // last pop, or a wrap onto the read index
                if (wr_n == rd_n) state_n = CH_EMPTY;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= CH_EMPTY;
            wr_q      <= '0;
            rd_q      <= '0;
            overrun_q <= 1'b0;
        end else begin
            state_q   <= state_n;
            wr_q      <= wr_n;
            rd_q      <= rd_n;
            overrun_q <= overrun_n;
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wr_q] <= push_char;
    end

    always_comb begin
        avail     = (state_q == CH_HOLDING);
        head_char = mem[rd_q];
    end
endmodule

// File: rtl/rxq_steer.sv
module rxq_steer
    import rxq_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic                 data_wr,
    input  logic                 data_rd,
    input  logic                 acc_chan,
    input  logic [CW-1:0]        wr_char,
    input  logic [NUM_CH-1:0]    loopback,
    input  logic [NUM_CH-1:0]    ext_push,
    input  logic [NUM_CH*CW-1:0] ext_char,
    output logic [NUM_CH-1:0]    push,
    output logic [NUM_CH*CW-1:0] push_char,
    output logic [NUM_CH-1:0]    pop
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic hit, loop_push;
        assign hit       = (acc_chan == 1'(c));
        assign loop_push = data_wr && hit && loopback[c];
        // loopback byte wins over an external character on the same channel
        assign push[c]   = loop_push || ext_push[c];
        assign push_char[c*CW +: CW] = loop_push ? wr_char : ext_char[c*CW +: CW];
        assign pop[c]    = data_rd && hit;
    end
endmodule

// File: rtl/rxq_pend_ctrl.sv
module rxq_pend_ctrl
    import rxq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_ie,
    input  logic [1:0]        rx_mode,
    input  logic [NUM_CH-1:0] tx_ie,
    input  logic [NUM_CH-1:0] avail,
    input  logic              data_wr,
    input  logic              data_rd,
    input  logic              acc_chan,
    output logic [PEND_W-1:0] pending_q,
    output logic              irq
);
    irq_state_t        irq_q, irq_n;
    logic [PEND_W-1:0] sets, pending_n;

    always_comb begin
        sets = '0;
        if (master_ie) begin
            for (int c = 0; c < NUM_CH; c++) begin
                if ((rx_mode != 2'b00) && avail[c])
                    sets[PEND_RX_BASE + c] = 1'b1;
                if (data_wr && (acc_chan == 1'(c)) && tx_ie[c])
                    sets[PEND_TX_BASE + c] = 1'b1;
            end
        end
        // a data read acknowledges everything; it takes priority
        pending_n = data_rd ? '0 : (pending_q | sets);
    end

    always_comb begin
        irq_n = irq_q;
        unique case (irq_q)
            IRQ_QUIET: begin
                if (master_ie && (pending_q != '0)) irq_n = IRQ_RAISED;
            end
            IRQ_RAISED: begin
                if (!master_ie || (pending_q == '0)) irq_n = IRQ_QUIET;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending_q <= '0;
            irq_q     <= IRQ_QUIET;
        end else begin
            pending_q <= pending_n;
            irq_q     <= irq_n;
        end
    end

    assign irq = (irq_q == IRQ_RAISED);
endmodule

// File: rtl/sio_rx_status.sv
module sio_rx_status
    import rxq_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int CW    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_CH-1:0]    ext_push,
    input  logic [NUM_CH*CW-1:0] ext_char,
    input  logic                 data_rd,
    input  logic                 data_wr,
    input  logic                 acc_chan,
    input  logic [CW-1:0]        wr_char,
    input  logic                 master_ie,
    input  logic [1:0]           rx_mode,
    input  logic [NUM_CH-1:0]    tx_ie,
    input  logic [NUM_CH-1:0]    loopback,
    output logic [CW-1:0]        rd_char,
    output logic [NUM_CH-1:0]    rx_avail,
    output logic [NUM_CH-1:0]    tx_empty,
    output logic [NUM_CH-1:0]    overrun,
    output logic [PEND_W-1:0]    pending,
    output logic                 irq
);
    logic [NUM_CH-1:0]    push, pop;
    logic [NUM_CH*CW-1:0] push_char, head_char;

    rxq_steer #(.CW(CW)) u_steer (
        .data_wr   (data_wr),
        .data_rd   (data_rd),
        .acc_chan  (acc_chan),
        .wr_char   (wr_char),
        .loopback  (loopback),
        .ext_push  (ext_push),
        .ext_char  (ext_char),
        .push      (push),
        .push_char (push_char),
        .pop       (pop)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_q
        rxq_channel #(.DEPTH(DEPTH), .CW(CW)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (push[c]),
            .push_char (push_char[c*CW +: CW]),
            .pop       (pop[c]),
            .avail     (rx_avail[c]),
            .head_char (head_char[c*CW +: CW]),
            .overrun_q (overrun[c])
        );
    end

    rxq_pend_ctrl u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .master_ie (master_ie),
        .rx_mode   (rx_mode),
        .tx_ie     (tx_ie),
        .avail     (rx_avail),
        .data_wr   (data_wr),
        .data_rd   (data_rd),
        .acc_chan  (acc_chan),
        .pending_q (pending),
        .irq       (irq)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_char <= '0;
        end else if (data_rd) begin
            rd_char <= rx_avail[acc_chan] ? head_char[acc_chan*CW +: CW] : '0;
        end
    end

    assign tx_empty = '1;
endmodule

// File: rtl/rxq_checker.sv
module rxq_checker
    import rxq_pkg::*;
#(
    parameter int CW = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              data_rd,
    input logic              data_wr,
    input logic              acc_chan,
    input logic              master_ie,
    input logic [1:0]        rx_mode,
    input logic [NUM_CH-1:0] tx_ie,
    input logic [CW-1:0]     rd_char,
    input logic [NUM_CH-1:0] rx_avail,
    input logic [NUM_CH-1:0] overrun,
    input logic [PEND_W-1:0] pending,
    input logic              irq
);
    a_r2_overrun_a_empty: assert property (@(posedge clk) disable iff (!rst_n)
        overrun[0] |-> !rx_avail[0]);
    a_r2_overrun_b_empty: assert property (@(posedge clk) disable iff (!rst_n)
        overrun[1] |-> !rx_avail[1]);
    a_r4_no_rise_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !master_ie |=> ((pending & ~$past(pending)) == 4'b0000));
    a_r5_rx_pend_a: assert property (@(posedge clk) disable iff (!rst_n)
        (master_ie && rx_mode != 2'b00 && rx_avail[0] && !data_rd) |=> pending[0]);
    a_r5_rx_pend_b: assert property (@(posedge clk) disable iff (!rst_n)
        (master_ie && rx_mode != 2'b00 && rx_avail[1] && !data_rd) |=> pending[1]);
    a_r6_tx_pend_a: assert property (@(posedge clk) disable iff (!rst_n)
        (master_ie && data_wr && !acc_chan && tx_ie[0] && !data_rd) |=> pending[2]);
    a_r6_tx_pend_b: assert property (@(posedge clk) disable iff (!rst_n)
        (master_ie && data_wr && acc_chan && tx_ie[1] && !data_rd) |=> pending[3]);
    a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        data_rd |=> (pending == 4'b0000));
    a_r9_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !rx_avail[acc_chan]) |=> (rd_char == '0));
    a_r11_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (master_ie && pending != 4'b0000) |=> irq);
    a_r11_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !(master_ie && pending != 4'b0000) |=> !irq);
endmodule

bind sio_rx_status rxq_checker #(.CW(CW)) u_rxq_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .data_rd   (data_rd),
    .data_wr   (data_wr),
    .acc_chan  (acc_chan),
    .master_ie (master_ie),
    .rx_mode   (rx_mode),
    .tx_ie     (tx_ie),
    .rd_char   (rd_char),
    .rx_avail  (rx_avail),
    .overrun   (overrun),
    .pending   (pending),
    .irq       (irq)
);

// File: tb/sio_rx_status_bench.sv
`timescale 1ns/1ps
module sio_rx_status_bench;
    localparam int DEPTH = 1024;
    localparam int MAX_CYCLES = 150000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  ext_push;
    logic [15:0] ext_char;
    logic        data_rd, data_wr, acc_chan;
    logic [7:0]  wr_char;
    logic        master_ie;
    logic [1:0]  rx_mode, tx_ie, loopback;
    logic [7:0]  rd_char;
    logic [1:0]  rx_avail, tx_empty, overrun;
    logic [3:0]  pending;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench reference model
    logic [7:0] m_mem [2][DEPTH];
    int         m_wr [2];
    int         m_rd [2];
    logic [3:0] m_pend;
    logic       m_irq;
    logic [7:0] m_rdc;
    logic [1:0] m_ovr;

    always #2.5 clk = ~clk;

    sio_rx_status #(.DEPTH(DEPTH), .CW(8)) u_sio_rx_status (
        .clk(clk), .rst_n(rst_n), .ext_push(ext_push), .ext_char(ext_char),
        .data_rd(data_rd), .data_wr(data_wr), .acc_chan(acc_chan),
        .wr_char(wr_char), .master_ie(master_ie), .rx_mode(rx_mode),
        .tx_ie(tx_ie), .loopback(loopback), .rd_char(rd_char),
        .rx_avail(rx_avail), .tx_empty(tx_empty), .overrun(overrun),
        .pending(pending), .irq(irq)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] m_avail();
        return {logic'(m_wr[1] != m_rd[1]), logic'(m_wr[0] != m_rd[0])};
    endfunction

    task automatic model_step();
        logic [1:0] oa;
        logic [3:0] sets;
        int ch;
        oa = m_avail();
        ch = int'(acc_chan);
        m_irq = master_ie && (m_pend != 4'b0);
        sets = 4'b0;
        if (master_ie && rx_mode != 2'b00) sets[1:0] = oa;
        if (master_ie && data_wr && tx_ie[ch]) sets[2 + ch] = 1'b1;
        m_pend = data_rd ? 4'b0 : (m_pend | sets);
        if (data_rd) begin
            if (oa[ch]) begin
                m_rdc = m_mem[ch][m_rd[ch]];
                m_rd[ch] = (m_rd[ch] + 1) % DEPTH;
            end else begin
                m_rdc = 8'h00;
            end
        end
        for (int c = 0; c < 2; c++) begin
            logic       p;
            logic [7:0] v;
            p = 1'b0;
            v = 8'h00;
            if (data_wr && ch == c && loopback[c]) begin p = 1'b1; v = wr_char; end
            else if (ext_push[c]) begin p = 1'b1; v = ext_char[c*8 +: 8]; end
            m_ovr[c] = 1'b0;
            if (p) begin
                m_mem[c][m_wr[c]] = v;
                m_wr[c] = (m_wr[c] + 1) % DEPTH;
                m_ovr[c] = (m_wr[c] == m_rd[c]);
            end
        end
    endtask

    task automatic compare();
        chk("R3 rx_avail", 16'(rx_avail), 16'(m_avail()));
        chk("R3 tx_empty", 16'(tx_empty), 16'h0003);
        chk("R5 pending", 16'(pending), 16'(m_pend));
        chk("R11 irq", 16'(irq), 16'(m_irq));
        chk("R2 overrun", 16'(overrun), 16'(m_ovr));
        chk("R8 rd_char", 16'(rd_char), 16'(m_rdc));
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        model_step();
        compare();
    endtask

    task automatic idle();
        ext_push = 2'b00; ext_char = 16'h0; data_rd = 0; data_wr = 0;
        acc_chan = 0; wr_char = 8'h0;
    endtask

    task automatic drain();
        idle();
        master_ie = 0;
        for (int c = 0; c < 2; c++) begin
            while (m_wr[c] != m_rd[c]) begin
                data_rd = 1; acc_chan = 1'(c);
                tick();
            end
        end
        idle();
        tick();
    endtask

    initial begin
        #(MAX_CYCLES * 5.0);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        idle();
        master_ie = 0; rx_mode = 2'b00; tx_ie = 2'b00; loopback = 2'b00;
        m_wr = '{0, 0}; m_rd = '{0, 0};
        m_pend = 4'b0; m_irq = 0; m_rdc = 8'h0; m_ovr = 2'b0;
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1;
        // R12: reset state
        chk("R12 rx_avail", 16'(rx_avail), 16'h0);
        chk("R12 pending", 16'(pending), 16'h0);
        chk("R12 irq", 16'(irq), 16'h0);
        chk("R12 rd_char", 16'(rd_char), 16'h0);
        chk("R12 overrun", 16'(overrun), 16'h0);
        @(negedge clk);
        rst_n = 1;
        tick();

        // R1: FIFO order
        for (int i = 0; i < 3; i++) begin
            ext_push = 2'b01; ext_char = 16'(8'h31 + i);
            tick();
        end
        idle();
        for (int i = 0; i < 3; i++) begin
            data_rd = 1; acc_chan = 0;
            tick();
            chk("R1 order", 16'(rd_char), 16'(8'h31 + i));
        end
        idle(); tick();
        chk("R3 emptied", 16'(rx_avail), 16'h0);

        // R9: read of empty queue B
        data_rd = 1; acc_chan = 1;
        tick();
        chk("R9 empty read", 16'(rd_char), 16'h0);
        chk("R9 still empty", 16'(rx_avail), 16'h0);
        idle(); tick();

        // R7: loopback byte beats the external push on channel A
        loopback = 2'b01;
        data_wr = 1; acc_chan = 0; wr_char = 8'h5A; ext_push = 2'b01; ext_char = 16'h0011;
        tick();
        idle(); loopback = 2'b00;
        data_rd = 1; acc_chan = 0;
        tick();
        chk("R7 looped byte", 16'(rd_char), 16'h005A);
        chk("R7 external dropped", 16'(rx_avail), 16'h0);
        idle(); tick();

        // R10: push and pop on A in the same cycle
        ext_push = 2'b01; ext_char = 16'h0070;
        tick();
        ext_push = 2'b01; ext_char = 16'h0071; data_rd = 1; acc_chan = 0;
        tick();
        chk("R10 popped head", 16'(rd_char), 16'h0070);
        chk("R10 push kept", 16'(rx_avail), 16'h0001);
        idle(); data_rd = 1; acc_chan = 0;
        tick();
        chk("R10 second char", 16'(rd_char), 16'h0071);
        idle(); tick();

        // R4: master enable off, data present, nothing pends
        rx_mode = 2'b11; tx_ie = 2'b11;
        ext_push = 2'b10; ext_char = 16'h4200;
        tick();
        idle(); data_wr = 1; acc_chan = 1; wr_char = 8'h01;
        tick();
        idle(); tick(); tick();
        chk("R4 no pending", 16'(pending), 16'h0);
        chk("R4 no irq", 16'(irq), 16'h0);

        // R5 then R11 then R8 clear
        master_ie = 1; tx_ie = 2'b00;
        tick();
        chk("R5 rx pend B", 16'(pending[1]), 16'h1);
        tick();
        chk("R11 irq raised", 16'(irq), 16'h1);
        data_rd = 1; acc_chan = 1; ext_push = 2'b01; ext_char = 16'h0009;
        tick();
        chk("R8 clear wins", 16'(pending), 16'h0);
        chk("R8 popped B", 16'(rd_char), 16'h0042);
        drain();

        // R6: transmit pending on channel B
        master_ie = 1; rx_mode = 2'b00; tx_ie = 2'b10;
        data_wr = 1; acc_chan = 1; wr_char = 8'h44;
        tick();
        chk("R6 tx pend B", 16'(pending), 16'h0008);
        idle(); tick();
        chk("R11 irq from tx", 16'(irq), 16'h1);
        data_rd = 1; acc_chan = 0;
        tick();
        idle(); tick();
        chk("R11 irq drops", 16'(irq), 16'h0);
        master_ie = 0; tx_ie = 2'b00;

        // R2: overrun by filling queue B without pops
        for (int i = 0; i < DEPTH; i++) begin
            ext_push = 2'b10; ext_char = 16'((i & 8'hFF) << 8);
            tick();
        end
        idle();
        chk("R2 overrun pulse", 16'(overrun), 16'h0002);
        chk("R2 reads empty", 16'(rx_avail), 16'h0);
        tick();
        chk("R2 pulse ends", 16'(overrun), 16'h0);

        // random run with overlapping functions
        for (int n = 0; n < 4000; n++) begin
            master_ie = ($urandom % 8) != 0;
            rx_mode   = 2'($urandom);
            tx_ie     = 2'($urandom);
            loopback  = 2'($urandom);
            ext_push  = 2'($urandom) & 2'($urandom);
            ext_char  = 16'($urandom);
            data_rd   = ($urandom % 3) == 0;
            data_wr   = ($urandom % 3) == 0;
            acc_chan  = 1'($urandom);
            wr_char   = 8'($urandom);
            tick();
        end
        drain();

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule